// File: doc/BRIEF.md
# Dual-Bank Numerically Controlled Oscillator Core

This block is the phase-generation core of a direct digital synthesizer. Each rising edge of the master clock adds a tuning word to a 28-bit phase accumulator. The block then adds a 12-bit phase offset to the top twelve accumulator bits. The result is a registered 12-bit phase word, which goes to an external sine lookup. The lookup's 10-bit result comes back on `sine_in`, and the block registers it as the waveform code. In triangle mode the block builds the waveform code from the phase word itself instead.

The block holds two tuning words and two phase offsets. A control bit or an external pin selects the active tuning word, and a second bit or pin selects the active offset. A mode bit decides whether the pins or the bits are used. A simple parallel port writes all the registers. A datapath-clear input zeroes the running state but keeps the programmed registers. A sleep input or sleep bit parks the waveform at midscale while the accumulator keeps running. A sign output can carry either the phase MSB or an external comparator result.

Top module: `nco_phase_core`

## Requirements
- R1: On every clock edge without clear, the accumulator advances by the selected tuning word, modulo 2^28. Output frequency is word × f_clk / 2^28.
- R2: One edge after the accumulator value exists, `phase_word` becomes accumulator bits [27:16] plus the selected 12-bit offset, modulo 4096.
- R3: Control bit 2 picks the tuning-word select source. When the bit is 1, the source is `fsel_pin` as sampled on the previous rising edge. When it is 0, the source is control bit 0. Select 0 means address 0 and select 1 means address 1.
- R4: Offset selection works the same way with `psel_pin` and control bit 1. Select 0 means address 2 and select 1 means address 3.
- R5: A write with `wr_en` high updates one register on that edge, and the next edge's computation uses the new value. The addresses are: 0 = tuning word 0 (28 bits), 1 = tuning word 1, 2 = offset 0 (`wr_data[11:0]`), 3 = offset 1, 4 = control (`wr_data[6:0]`). Without a write, every register holds its value.
- R6: `dp_clr` high at an edge does three things on that edge: it zeroes the accumulator, it zeroes `phase_word`, and it loads 10'h200 into `wave_code`. All programmed registers stay unchanged, so the programmed frequency resumes once the clear ends.
- R7: While `sleep_in` or control bit 4 is high, `wave_code` is loaded with 10'h200 on each edge, and the accumulator and phase word keep advancing.
- R8: With control bit 3 at 0, `wave_code` registers `sine_in`. With bit 3 at 1, it registers a triangle built from the current phase word p: p[10:1] when p[11] is 0, and the bitwise inverse of p[10:1] when p[11] is 1.
- R9: `sign_out` is 0 when control bit 5 is 0. When bit 5 is 1, `sign_out` is `phase_word[11]` if control bit 6 is 1, and `cmp_in` if bit 6 is 0.
- R10: `rst_n` low is asynchronous. It clears every register, including tuning words, offsets and control. It leaves `phase_word` at 0, `wave_code` at 10'h200 and `sign_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous full reset, active low |
| dp_clr | input | 1 | Synchronous datapath clear, active high |
| sleep_in | input | 1 | Parks the waveform at midscale |
| fsel_pin | input | 1 | External tuning-word select |
| psel_pin | input | 1 | External phase-offset select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 28 | Write data |
| sine_in | input | 10 | Sine lookup result for the current `phase_word` |
| cmp_in | input | 1 | External comparator result |
| phase_word | output | 12 | Registered phase word for lookup |
| wave_code | output | 10 | Registered waveform code |
| sign_out | output | 1 | Selectable sign output |

## Verification
The assertions assume two things about the inputs: they are synchronous to `clk`, and `rst_n` is released away from a rising edge. The bench meets both by changing every input, the reset included, shortly after a falling edge. The assertions also assume that `sine_in` is a pure function of the current `phase_word`. The bench honours this by deriving `sine_in` combinationally from `phase_word` and never driving it by itself. Writes, pin toggles, clears and sleeps are allowed to collide in the same cycle, because the assertions make no assumption about how often they occur.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [2:0] {
    A_FREQ0 = 3'd0,
    A_FREQ1 = 3'd1,
    A_PHS0  = 3'd2,
    A_PHS1  = 3'd3,
    A_CTRL  = 3'd4
  } reg_addr_e;

  // packed MSB first: bit6 .. bit0
  typedef struct packed {
    logic sign_src;   // bit6: 1 = phase MSB, 0 = comparator
    logic sign_en;    // bit5
    logic sleep;      // bit4
    logic tri_mode;   // bit3
    logic pin_sel;    // bit2: selects come from pins
    logic psel;       // bit1
    logic fsel;       // bit0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import nco_pkg::*;
#(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              fsel_pin,
  input  logic              psel_pin,
  output logic [ACC_W-1:0]  step_word,
  output logic [PH_W-1:0]   offset_word,
  output ctrl_t             ctrl
);

  localparam int NBANK = 2;

  logic [NBANK-1:0][ACC_W-1:0] freq_q;
  logic [NBANK-1:0][PH_W-1:0]  phs_q;
  ctrl_t                       ctrl_q;
  logic                        fsel_q, psel_q;
  logic                        fsel_eff, psel_eff;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return a == ADDR_W'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      phs_q  <= '0;
      ctrl_q <= '0;
      fsel_q <= 1'b0;
      psel_q <= 1'b0;
    end else begin
      fsel_q <= fsel_pin;
      psel_q <= psel_pin;
      if (wr_en) begin
        for (int b = 0; b < NBANK; b++) begin
          if (hit(wr_addr, reg_addr_e'(int'(A_FREQ0) + b))) freq_q[b] <= wr_data;
          if (hit(wr_addr, reg_addr_e'(int'(A_PHS0) + b)))  phs_q[b]  <= wr_data[PH_W-1:0];
        end
        if (hit(wr_addr, A_CTRL)) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      end
    end
  end

  assign fsel_eff    = ctrl_q.pin_sel ? fsel_q : ctrl_q.fsel;
  assign psel_eff    = ctrl_q.pin_sel ? psel_q : ctrl_q.psel;
  assign step_word   = freq_q[fsel_eff];
  assign offset_word = phs_q[psel_eff];
  assign ctrl        = ctrl_q;

  // R5
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(freq_q) && $stable(phs_q) && $stable(ctrl_q)));

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_clr,
  input  logic [ACC_W-1:0] step_word,
  input  logic [PH_W-1:0]  offset_word,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  phase_q
);

  function automatic logic [ACC_W-1:0] acc_next(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] s);
    return a + s;  // modulo 2^ACC_W
  endfunction

  function automatic logic [PH_W-1:0] phase_sum(input logic [ACC_W-1:0] a,
                                                input logic [PH_W-1:0] o);
    return a[ACC_W-1 -: PH_W] + o;  // modulo 2^PH_W
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else if (dp_clr) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_next(acc_q, step_word);
      phase_q <= phase_sum(acc_q, offset_word);
    end
  end

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_clr |=> (acc_q == '0 && phase_q == '0));

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_clr && step_word == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_shape.sv
module nco_shape #(
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_clr,
  input  logic             sleep_any,
  input  logic             tri_mode,
  input  logic [PH_W-1:0]  phase_q,
  input  logic [OUT_W-1:0] sine_in,
  input  logic             sign_en,
  input  logic             sign_src,
  input  logic             cmp_in,
  output logic [OUT_W-1:0] wave_q,
  output logic             sign_out
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

  function automatic logic [OUT_W-1:0] tri_fold(input logic [PH_W-1:0] p);
    logic [OUT_W-1:0] mag;
    mag = p[PH_W-2 -: OUT_W];
    return p[PH_W-1] ? ~mag : mag;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wave_q <= MID;
    else if (dp_clr || sleep_any) wave_q <= MID;
    else if (tri_mode)            wave_q <= tri_fold(phase_q);
    else                          wave_q <= sine_in;
  end

  assign sign_out = sign_en & (sign_src ? phase_q[PH_W-1] : cmp_in);

  // R7
  sleep_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_any || dp_clr) |=> (wave_q == MID));

  // R9
  sign_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_en |-> !sign_out);

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_clr,
  input  logic              sleep_in,
  input  logic              fsel_pin,
  input  logic              psel_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic [OUT_W-1:0]  sine_in,
  input  logic              cmp_in,
  output logic [PH_W-1:0]   phase_word,
  output logic [OUT_W-1:0]  wave_code,
  output logic              sign_out
);

  logic [ACC_W-1:0] step_word;
  logic [PH_W-1:0]  offset_word;
  ctrl_t            ctrl;
  logic [ACC_W-1:0] acc_q;
  logic             sleep_any;

  nco_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsel_pin(fsel_pin), .psel_pin(psel_pin),
    .step_word(step_word), .offset_word(offset_word), .ctrl(ctrl)
  );

  nco_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .dp_clr(dp_clr), .step_word(step_word),
    .offset_word(offset_word), .acc_q(acc_q), .phase_q(phase_word)
  );

  assign sleep_any = sleep_in | ctrl.sleep;

  nco_shape #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .dp_clr(dp_clr), .sleep_any(sleep_any),
    .tri_mode(ctrl.tri_mode), .phase_q(phase_word), .sine_in(sine_in),
    .sign_en(ctrl.sign_en), .sign_src(ctrl.sign_src), .cmp_in(cmp_in),
    .wave_q(wave_code), .sign_out(sign_out)
  );

  // R10
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (phase_word == '0 && !sign_out));

endmodule

// File: tb/sim_nco_phase_core.sv
module sim_nco_phase_core;

  localparam int PERIOD = 10;
  localparam int MASK28 = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dp_clr = 1'b0, sleep_in = 1'b0, fsel_pin = 1'b0, psel_pin = 1'b0;
  logic        wr_en = 1'b0, cmp_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic [9:0]  sine_in;
  logic [11:0] phase_word;
  logic [9:0]  wave_code;
  logic        sign_out;

  int n_vec = 0, n_bad = 0;
  string cur_req = "R10";
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  // stand-in lookup: a pure function of the phase word
  assign sine_in = phase_word[11:2] ^ 10'h2A5;

  nco_phase_core u0 (
    .clk(clk), .rst_n(rst_n), .dp_clr(dp_clr), .sleep_in(sleep_in),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sine_in(sine_in), .cmp_in(cmp_in),
    .phase_word(phase_word), .wave_code(wave_code), .sign_out(sign_out)
  );

  // behavioural reference model
  int unsigned m_acc, m_ph, m_wave, m_ctrl, m_fp, m_pp;
  int unsigned m_freq[2], m_phs[2];

  function automatic int unsigned m_sine(int unsigned p);
    return ((p >> 2) ^ 32'h2A5) & 32'h3FF;
  endfunction

  function automatic int unsigned m_tri(int unsigned p);
    int unsigned mag = (p >> 1) & 32'h3FF;
    return (p >= 2048) ? (1023 - mag) : mag;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_ph = 0; m_wave = 512; m_ctrl = 0; m_fp = 0; m_pp = 0;
      m_freq[0] = 0; m_freq[1] = 0; m_phs[0] = 0; m_phs[1] = 0;
    end else begin
      int unsigned fs, ps, n_acc, n_ph, n_wave;
      fs = m_ctrl[2] ? m_fp : m_ctrl[0];
      ps = m_ctrl[2] ? m_pp : m_ctrl[1];
      n_acc = dp_clr ? 0 : (m_acc + m_freq[fs]) & MASK28;
      n_ph  = dp_clr ? 0 : ((m_acc >> 16) + m_phs[ps]) & 32'hFFF;
      if (dp_clr || sleep_in || m_ctrl[4]) n_wave = 512;
      else if (m_ctrl[3])                  n_wave = m_tri(m_ph);
      else                                 n_wave = m_sine(m_ph);
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_freq[0] = wr_data;
          3'd1: m_freq[1] = wr_data;
          3'd2: m_phs[0]  = wr_data & 32'hFFF;
          3'd3: m_phs[1]  = wr_data & 32'hFFF;
          3'd4: m_ctrl    = wr_data & 32'h7F;
          default: ;
        endcase
      end
      m_fp = fsel_pin; m_pp = psel_pin;
      m_acc = n_acc; m_ph = n_ph; m_wave = n_wave;
    end
  end

  task automatic check(string what, int unsigned act, int unsigned exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every clock, before the stimulus moves
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int unsigned s_exp;
      s_exp = m_ctrl[5] ? (m_ctrl[6] ? (m_ph >> 11) : cmp_in) : 0;
      check("phase_word", phase_word, m_ph);
      check("wave_code", wave_code, m_wave);
      check("sign_out", sign_out, s_exp);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(int a, int unsigned d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 28'(d);
    step(); wr_en = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s timeout actual=running expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    step(3);
    cur_req = "R10";
    check("reset phase", phase_word, 0);
    check("reset wave", wave_code, 10'h200);
    check("reset sign", sign_out, 0);
    rst_n = 1;
    step(4);

    // R5 and R1: program and run, including wrap
    cur_req = "R5";
    wr(0, 32'h0100_0000);
    step(10);
    cur_req = "R1";
    wr(0, 32'h0FF0_0001);
    step(40);

    // R2: offsets via control bit
    cur_req = "R2";
    wr(2, 32'h123); wr(3, 32'hABC);
    step(8);
    wr(4, 32'h02); step(8);
    wr(4, 32'h00); step(4);

    // R3: tuning select by bit and by pin
    cur_req = "R3";
    wr(1, 32'h0034_5678);
    wr(4, 32'h01); step(10);
    wr(4, 32'h04);
    for (int i = 0; i < 30; i++) begin
      fsel_pin = (i % 3 == 0) ? ~fsel_pin : fsel_pin; step();
    end

    // R4: offset select by pin
    cur_req = "R4";
    for (int i = 0; i < 30; i++) begin
      psel_pin = (i % 2 == 0) ? ~psel_pin : psel_pin; step();
    end

    // R8: triangle and back
    cur_req = "R8";
    wr(4, 32'h08); step(60);
    wr(4, 32'h00); step(10);

    // R7: sleep by pin and by bit
    cur_req = "R7";
    sleep_in = 1; step(15); sleep_in = 0; step(5);
    wr(4, 32'h18); step(15); wr(4, 32'h08); step(5);

    // R6: datapath clear keeps registers
    cur_req = "R6";
    dp_clr = 1; step(3); dp_clr = 0; step(20);
    dp_clr = 1; wr(0, 32'h0000_8000); dp_clr = 0; step(20);

    // R9: sign output modes
    cur_req = "R9";
    wr(0, 32'h0200_0000);
    wr(4, 32'h20);
    for (int i = 0; i < 20; i++) begin cmp_in = $urandom_range(0, 1); step(); end
    wr(4, 32'h60); step(30);
    wr(4, 32'h40);
    for (int i = 0; i < 10; i++) begin cmp_in = ~cmp_in; step(); end

    // mixed traffic across all requirements
    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      wr_en    = ($urandom_range(0, 3) == 0);
      wr_addr  = 3'($urandom_range(0, 4));
      wr_data  = 28'($urandom);
      fsel_pin = $urandom_range(0, 1);
      psel_pin = $urandom_range(0, 1);
      cmp_in   = $urandom_range(0, 1);
      dp_clr   = ($urandom_range(0, 15) == 0);
      sleep_in = ($urandom_range(0, 15) == 0);
      step();
    end
    wr_en = 0; dp_clr = 0; sleep_in = 0;
    step(5);

    // R10: mid-run reset clears the registers too
    cur_req = "R10";
    wr(0, 32'h0123_4567); wr(4, 32'h60); step(5);
    rst_n = 0; step(2);
    check("async reset phase", phase_word, 0);
    check("async reset wave", wave_code, 10'h200);
    check("async reset sign", sign_out, 0);
    rst_n = 1; step(10);
    check("cleared tuning word", phase_word, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule